// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frame bytes into memory buffers that software has supplied. The buffers are described by a ring of two-word descriptors. Software gives each descriptor to the hardware by setting its empty flag. The engine fetches a descriptor when a frame starts and packs the incoming bytes little-endian into 32-bit words. When a buffer fills, or the frame ends, it writes the length and status back into the descriptor and clears the empty flag. This returns the buffer to software. All buffers share one size. A frame that is longer than one buffer continues in the next descriptor of the ring.

The memory side is a single word-wide master port. Every request completes in the cycle it is issued, and read data arrives on the following cycle. The byte side is a stream with start and end markers. The engine holds its ready low while it fetches or writes. One-cycle pulses report a completed frame and a frame lost because no empty descriptor was available.

Top module: `rxdesc_ring_dma`

## Requirements
- R1: Descriptors sit 8 bytes apart from the ring base. After a descriptor whose wrap flag (status bit 13, word bit 29) is set, the next descriptor fetched is at the ring base. After any other descriptor, the next one is at the previous address plus 8.
- R2: A descriptor is used only if its empty flag (status bit 15, word bit 31) is set. Word 0 holds the status in bits 31:16 and the length in bits 15:0. Word 1, at +4, holds the buffer address. The write-back leaves the empty flag clear.
- R3: Every buffer holds the same number of bytes, given by the buffer-size input with its two low bits treated as zero. When a frame outgrows its buffer, that descriptor is closed with length equal to the buffer size and with the last flag (status bit 11) clear.
- R4: The descriptor that receives the final byte of a frame is closed with the last flag set and with the length equal to the whole frame length. The closing status keeps the descriptor's wrap flag, and every other status bit is zero.
- R5: While the enable input is low, the descriptor pointer returns to the ring base. The two low bits of the base are ignored.
- R6: Frame byte k goes to buffer address + 4*(k/4), in byte lane k%4 (bits 8*(k%4)+7 down to 8*(k%4)). A partial final word is written with only its filled lanes enabled.
- R7: If the descriptor is not empty when a frame needs it, `overrun` pulses for one cycle. The rest of that frame is accepted and discarded without any memory access, and the pointer stays on that descriptor.
- R8: `frame_done` pulses for one cycle, in the same cycle as the write-back that sets the last flag.
- R9: Bytes that arrive with no start marker while the engine is idle, or while it is disabled, are accepted and discarded without any memory access.
- R10: Every memory address issued is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Engine enable; low holds the pointer at the ring base |
| cfg_ring_base | input | ADDR_W | Address of the first descriptor |
| cfg_buf_size | input | LEN_W | Bytes per receive buffer (low two bits ignored) |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Engine accepts the stream byte this cycle |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| mem_req | output | 1 | Memory request, completes this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| frame_done | output | 1 | One-cycle pulse when a frame is closed |
| overrun | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The bench keeps the default 32-bit address and 16-bit length widths. At run time it programs a four-descriptor ring with 16-byte buffers, which is small enough that a 37-byte frame spans three descriptors and wraps the ring. It then reprograms the engine with a two-descriptor ring at an unaligned base and a buffer size of 19. This checks that the low bits of both inputs are ignored, and it produces an overrun in the middle of a frame after a wrap.

// File: rtl/rxdma_pkg.sv
// Shared definitions for the receive descriptor ring engine.
// Assumes 32-bit memory words and two-word descriptors.
package rxdma_pkg;
    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / 8;
    localparam int DESC_BYTES = 8;
    // status bit positions inside the 16-bit status half of word 0
    localparam int ST_EMPTY   = 15;
    localparam int ST_WRAP    = 13;
    localparam int ST_LAST    = 11;
    // the status half sits above the length half
    localparam int ST_OFS     = 16;

    typedef enum logic [2:0] {
        S_IDLE, S_RD0, S_CHK0, S_CAP1, S_DATA, S_WRW, S_CLOSE, S_DROP
    } rxdma_state_t;
endpackage

// File: rtl/rxdma_ptr.sv
// Descriptor pointer of the ring.
// Holds the address of the current descriptor. It returns to the aligned
// base whenever the engine is disabled or reset, and it steps or wraps
// when a descriptor is closed.
module rxdma_ptr #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] base,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] base_al;

    // base with the two low address bits ignored
    assign base_al = {base[ADDR_W-1:2], 2'b00};

    // pointer register: home on reset/disable, step or wrap on close
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            ptr <= base_al;
        else if (advance)
            ptr <= wrap ? base_al : ptr + ADDR_W'(STEP);
    end

    // R5: a disabled cycle leaves the pointer at the base seen in that cycle
    a_r5_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ptr == $past(base_al));
    // R1: a close without wrap moves exactly one descriptor forward
    a_r1_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && advance && !wrap) |=> ptr == $past(ptr) + ADDR_W'(STEP));
endmodule

// File: rtl/rxdma_pack.sv
// Byte-to-word packer.
// Gathers stream bytes little-endian into one memory word and tracks
// which lanes hold data. Assumes that clear and push never coincide
// (if they do, clear wins).
module rxdma_pack #(
    parameter int LANES = 4,
    localparam int LW   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               push,
    input  logic [7:0]         din,
    output logic [LANES*8-1:0] word,
    output logic [LANES-1:0]   be,
    output logic [LW-1:0]      lane
);
    // lane pointer and byte-enable tracking
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lane <= '0;
            be   <= '0;
        end else if (push) begin
            lane     <= lane + LW'(1);
            be[lane] <= 1'b1;
        end
    end

    // one data register per lane, loaded when its lane is addressed
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                word[g*8 +: 8] <= '0;
            else if (push && !clear && lane == LW'(g))
                word[g*8 +: 8] <= din;
        end
    end

    // R6: filled lanes always form a contiguous run from lane 0
    a_r6_be_contig: assert property (@(posedge clk) disable iff (!rst_n)
        (be & (be + LANES'(1))) == '0);
endmodule

// File: rtl/rxdesc_ring_dma.sv
// Receive descriptor ring DMA engine (top).
// When a frame starts, it fetches the descriptor at the ring pointer, checks
// that the descriptor is empty, reads the buffer address and packs the stream
// bytes into that buffer. It closes the descriptor when the buffer fills or
// the frame ends. Assumes a memory that completes each request in the same
// cycle and returns read data one cycle later. Also assumes buffer and ring
// addresses are word aligned and that the buffer size is at least 4.
module rxdesc_ring_dma
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic [LEN_W-1:0]  cfg_buf_size,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic [31:0]       mem_rdata,
    output logic              frame_done,
    output logic              overrun
);
    localparam int LW = $clog2(LANES);

    rxdma_state_t      state;
    logic [ADDR_W-1:0] ptr, waddr;
    logic [LEN_W-1:0]  buf_cnt, frame_len, bs_eff;
    logic              wrap_q, last_q, accept, desc_free, buf_full;
    logic [WORD_W-1:0] pk_word;
    logic [LANES-1:0]  pk_be;
    logic [LW-1:0]     pk_lane;
    logic [15:0]       close_status;

    assign bs_eff    = {cfg_buf_size[LEN_W-1:2], 2'b00};
    assign accept    = rx_valid && rx_ready;
    assign desc_free = mem_rdata[ST_OFS + ST_EMPTY];
    assign buf_full  = (buf_cnt == bs_eff);

    rxdma_ptr #(.ADDR_W(ADDR_W), .STEP(DESC_BYTES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .base(cfg_ring_base),
        .advance(state == S_CLOSE), .wrap(wrap_q), .ptr(ptr)
    );

    rxdma_pack #(.LANES(LANES)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .clear(state == S_WRW || state == S_CAP1),
        .push(state == S_DATA && accept),
        .din(rx_data), .word(pk_word), .be(pk_be), .lane(pk_lane)
    );

    // stream ready: open while discarding or filling, closed while the engine fetches or writes
    always_comb begin
        unique case (state)
            S_IDLE:         rx_ready = !(rx_valid && rx_sof && cfg_enable);
            S_DATA, S_DROP: rx_ready = 1'b1;
            default:        rx_ready = 1'b0;
        endcase
    end

    // closing status: keeps the wrap flag, sets the last flag at the end of a frame
    always_comb begin
        close_status = '0;
        close_status[ST_WRAP] = wrap_q;
        close_status[ST_LAST] = last_q;
    end

    // memory port drive for each state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = pk_word;
        mem_be    = '1;
        unique case (state)
            S_RD0:  mem_req = 1'b1;
            S_CHK0: begin
                mem_req  = desc_free;
                mem_addr = ptr + ADDR_W'(4);
            end
            S_WRW: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = waddr;
                mem_be   = pk_be;
            end
            S_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {close_status, 16'(last_q ? frame_len : buf_cnt)};
            end
            default: ;
        endcase
    end

    assign frame_done = (state == S_CLOSE) && last_q;
    assign overrun    = (state == S_CHK0) && !desc_free;

    // sequencer: fetch, fill, write back, and drop on a descriptor that is not empty
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_enable) begin
            state     <= S_IDLE;
            wrap_q    <= 1'b0;
            last_q    <= 1'b0;
            waddr     <= '0;
            buf_cnt   <= '0;
            frame_len <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (rx_valid && rx_sof) begin
                    frame_len <= '0;
                    last_q    <= 1'b0;
                    state     <= S_RD0;
                end
                S_RD0: state <= S_CHK0;
                S_CHK0: if (desc_free) begin
                    wrap_q <= mem_rdata[ST_OFS + ST_WRAP];
                    state  <= S_CAP1;
                end else begin
                    state <= S_DROP;
                end
                S_CAP1: begin
                    waddr   <= ADDR_W'({mem_rdata[31:2], 2'b00});
                    buf_cnt <= '0;
                    state   <= S_DATA;
                end
                S_DATA: if (accept) begin
                    buf_cnt   <= buf_cnt + LEN_W'(1);
                    frame_len <= frame_len + LEN_W'(1);
                    last_q    <= rx_eof;
                    if (pk_lane == LW'(LANES - 1) || rx_eof ||
                        buf_cnt + LEN_W'(1) == bs_eff)
                        state <= S_WRW;
                end
                S_WRW: begin
                    waddr <= waddr + ADDR_W'(LANES);
                    state <= (last_q || buf_full) ? S_CLOSE : S_DATA;
                end
                S_CLOSE: state <= last_q ? S_IDLE : S_RD0;
                S_DROP: if (accept && rx_eof) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2: filling starts only after a fetched word 0 showed the empty flag
    a_r2_owned_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CAP1) |-> $past(mem_rdata[ST_OFS + ST_EMPTY]));
    // R10: every address on the memory port is word aligned
    a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);
    // R8: frame completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    // R7: overrun is a single-cycle pulse and dropping never touches memory
    a_r7_overrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> !overrun);
    a_r7_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DROP) |-> !mem_req);
endmodule

// File: tb/tb_rxdesc_ring_dma.sv
`timescale 1ns/1ps
module tb_rxdesc_ring_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [31:0] cfg_ring_base = 32'h100;
    logic [15:0] cfg_buf_size = 16'd16;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, mem_req, mem_we, frame_done, overrun;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    rxdesc_ring_dma dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_ring_base(cfg_ring_base), .cfg_buf_size(cfg_buf_size),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rdata(mem_rdata), .frame_done(frame_done), .overrun(overrun)
    );

    // memory: same-cycle write, read data on the next cycle
    logic [31:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int i = 0; i < 4; i++)
                    if (mem_be[i]) mem[mem_addr[11:2]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[11:2]];
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    int  rbase, rn, bufbase, bs, eidx;
    bit  sw_empty [0:7];
    logic [31:0] qa[$], qd[$];
    logic [3:0]  qb[$];
    bit          qf[$];
    int  exp_ovr = 0, got_ovr = 0, exp_done = 0, got_done = 0;
    bit  quiet = 1'b0;

    function automatic logic [7:0] fbyte(int seed, int k);
        return 8'((seed + k * 7) & 255);
    endfunction

    task automatic push_wr(logic [31:0] a, logic [31:0] d, logic [3:0] b, bit f);
        qa.push_back(a); qd.push_back(d); qb.push_back(b); qf.push_back(f);
    endtask

    task automatic arm(int idx);
        logic [15:0] st;
        st = 16'h8000 | ((idx == rn - 1) ? 16'h2000 : 16'h0000);
        mem[(rbase + 8 * idx) >> 2]     = {st, 16'h0};
        mem[(rbase + 8 * idx + 4) >> 2] = bufbase + idx * 64;
        sw_empty[idx] = 1'b1;
    endtask

    // build the expected write sequence for one frame of len bytes
    task automatic model_frame(int len, int seed);
        int k = 0;
        while (1) begin
            int n, wr;
            logic [15:0] st;
            bit last;
            if (!sw_empty[eidx]) begin exp_ovr++; return; end
            sw_empty[eidx] = 1'b0;
            n = (len - k < bs) ? len - k : bs;
            for (int j = 0; j < n; j += 4) begin
                logic [31:0] d = '0;
                logic [3:0]  b = '0;
                for (int l = 0; l < 4; l++)
                    if (j + l < n) begin d[l*8 +: 8] = fbyte(seed, k + j + l); b[l] = 1'b1; end
                push_wr(bufbase + eidx * 64 + j, d, b, 1'b0);
            end
            k += n;
            last = (k == len);
            wr = (eidx == rn - 1);
            st = (last ? 16'h0800 : 16'h0) | (wr ? 16'h2000 : 16'h0);
            push_wr(rbase + 8 * eidx, {st, 16'(last ? len : bs)}, 4'hF, last);
            if (last) exp_done++;
            eidx = wr ? 0 : eidx + 1;
            if (last) return;
        end
    endtask

    // ---------------- per-clock comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_addr[1:0] != 2'b00) begin
                errors++;
                $display("FAIL R10: addr %h expected aligned", mem_addr);
            end
            if (quiet && mem_req) begin
                checks++; errors++;
                $display("FAIL R9: mem_req=1 expected 0 on discarded bytes");
            end
            if (overrun) got_ovr++;
            if (frame_done) got_done++;
            if (mem_req && mem_we) begin
                checks++;
                if (qa.size() == 0) begin
                    errors++;
                    $display("FAIL R7/R9: unexpected write addr %h data %h, expected none", mem_addr, mem_wdata);
                end else begin
                    logic [31:0] ea, ed, mk;
                    logic [3:0]  eb;
                    bit ef;
                    ea = qa.pop_front(); ed = qd.pop_front(); eb = qb.pop_front(); ef = qf.pop_front();
                    mk = {{8{eb[3]}}, {8{eb[2]}}, {8{eb[1]}}, {8{eb[0]}}};
                    if (mem_addr != ea || mem_be != eb || (mem_wdata & mk) != (ed & mk)) begin
                        errors++;
                        $display("FAIL R1-R6 write: got a=%h d=%h be=%h expected a=%h d=%h be=%h",
                                 mem_addr, mem_wdata & mk, mem_be, ea, ed & mk, eb);
                    end
                    if (frame_done != ef) begin
                        errors++;
                        $display("FAIL R8: frame_done=%0b expected %0b", frame_done, ef);
                    end
                end
            end else if (frame_done) begin
                checks++; errors++;
                $display("FAIL R8: frame_done=1 expected 0 without write-back");
            end
        end
    end

    task automatic send_frame(int len, int seed);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fbyte(seed, k);
            rx_sof = (k == 0); rx_eof = (k == len - 1);
            #0.5;
            while (!rx_ready) begin @(negedge clk); #0.5; end
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic frame(int len, int seed);
        model_frame(len, seed);
        send_frame(len, seed);
        repeat (12) @(negedge clk);
    endtask

    task automatic check(bit ok, string what, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic stray(int n);
        quiet = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'(k);
            #0.5;
            check(rx_ready == 1'b1, "R9 stray byte ready", int'(rx_ready), 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (4) @(negedge clk);
        quiet = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        rbase = 32'h100; rn = 4; bufbase = 32'h400; bs = 16; eidx = 0;
        for (int i = 0; i < 8; i++) sw_empty[i] = 1'b0;
        for (int i = 0; i < 4; i++) arm(i);
        repeat (4) @(negedge clk);
        // reset state
        check(mem_req == 1'b0, "reset mem_req", int'(mem_req), 0);
        check(frame_done == 1'b0, "R8 reset frame_done", int'(frame_done), 0);
        check(overrun == 1'b0, "R7 reset overrun", int'(overrun), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // disabled engine discards stray bytes (R9)
        stray(3);
        cfg_enable = 1'b1;
        @(negedge clk);
        check(rx_ready == 1'b1, "idle ready", int'(rx_ready), 1);
        frame(5, 3);          // R6 partial word, R4
        frame(16, 40);        // R3/R4 exact buffer
        arm(0);
        frame(37, 90);        // R3 spill, R1 wrap back to base
        frame(3, 11);         // R7 descriptor not empty at start of frame
        check(exp_ovr == 1, "R7 model overrun count", exp_ovr, 1);
        stray(4);             // R9 idle bytes without a start marker
        arm(1); arm(2);
        frame(20, 5);         // R3 spill into a partial buffer
        // R5: disable, move the ring to an unaligned base, odd buffer size
        @(negedge clk);
        cfg_enable = 1'b0;
        cfg_ring_base = 32'h201; cfg_buf_size = 16'd19;
        @(negedge clk);
        rbase = 32'h200; rn = 2; bufbase = 32'h800; bs = 16; eidx = 0;
        for (int i = 0; i < 8; i++) sw_empty[i] = 1'b0;
        arm(0); arm(1);
        cfg_enable = 1'b1;
        frame(8, 60);         // R5 first fetch at aligned base
        frame(40, 77);        // R1 wrap, R7 overrun in the middle of a frame
        check(qa.size() == 0, "R1-R6 writes outstanding", qa.size(), 0);
        check(got_ovr == exp_ovr, "R7 overrun pulses", got_ovr, exp_ovr);
        check(got_done == exp_done, "R8 frame_done pulses", got_done, exp_done);
        check(mem[32'h200 >> 2][31] == 1'b0, "R2 empty flag cleared", int'(mem[32'h200 >> 2][31]), 0);
        check(mem[32'h208 >> 2][31:16] == 16'h2000, "R3 intermediate status", int'(mem[32'h208 >> 2][31:16]), 16'h2000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule